// File: doc/BRIEF.md
# Tunable PTP Real-Time Clock

This block is the time base for a precision time protocol engine. It holds a 48-bit seconds count and a nanoseconds count with a 32-bit internal fraction. On every clock edge it adds a step size. The step size is a 40-bit period in fixed-point nanoseconds, so software can trim the rate by a tiny fraction of a nanosecond per cycle to cancel oscillator drift. The nanoseconds field rolls over at one billion and carries into the seconds field. The nominal setting is an 8 ns step for a 125 MHz timer clock.

Three load strobes control the clock. The first writes the time of day outright. The second replaces the nominal period. The third starts a timed correction. A timed correction swaps in an alternate period for a set number of cycles and then returns to the nominal period. This lets software slew the phase by a known amount without touching the nominal rate. A one-cycle completion pulse marks the end of the correction.

The outputs are the current seconds and the nanoseconds. The nanoseconds output carries the upper 8 bits of the fraction below the whole nanoseconds. The register file, host clock-domain crossing and packet timestamping sit outside this block.

Top module: `ptp_rtc`

## Requirements
- R1: While reset is asserted, and until the first load after it, seconds, nanoseconds and the done pulse are all zero, and the nominal period is zero, so time holds still.
- R2: A time load sets the time on the next edge. `now_sec` takes `time_sec_in`. `now_ns` takes `time_ns_in`, where bits 37:8 are whole nanoseconds and bits 7:0 are the fraction in units of 2^-8 ns. A time load wins over the accumulate step in the same cycle.
- R3: On each edge without a time load, the time advances by the active period. A period is 40 bits: bits 39:32 are whole nanoseconds and bits 31:0 are the fraction in units of 2^-32 ns. All 32 fraction bits accumulate internally, and only the top 8 appear on `now_ns[7:0]`.
- R4: When an accumulate step reaches 1,000,000,000 whole nanoseconds, that amount is removed and seconds go up by one. After any edge without a time load, `now_ns[37:8]` is below 1,000,000,000.
- R5: Seconds wrap from 2^48-1 to 0 when a nanosecond carry occurs.
- R6: A period load replaces the nominal period from the following edge. The step on the load edge still uses the previous period.
- R7: An adjustment load with count N>0 makes the N edges after the load edge step by `adj_period_in` (same format as the period) instead of the nominal period. After those N edges the nominal period applies again.
- R8: `adj_done` is high for exactly one cycle, right after the last of the N adjusted steps.
- R9: An adjustment load with count zero cancels any running adjustment from the next edge on, and raises no `adj_done`.
- R10: An adjustment load during a running adjustment restarts it with the new count and period. The abandoned adjustment raises no `adj_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_load | input | 1 | Strobe: write time of day |
| time_ns_in | input | 38 | Time load nanoseconds: 37:8 whole ns, 7:0 fraction (2^-8 ns) |
| time_sec_in | input | 48 | Time load seconds |
| period_load | input | 1 | Strobe: write nominal period |
| period_in | input | 40 | Nominal period: 39:32 whole ns, 31:0 fraction (2^-32 ns) |
| adj_load | input | 1 | Strobe: start or cancel a timed adjustment |
| adj_cycles_in | input | 32 | Number of edges the adjustment period applies |
| adj_period_in | input | 40 | Adjustment period, same format as `period_in` |
| adj_done | output | 1 | One-cycle pulse when an adjustment completes |
| now_sec | output | 48 | Current seconds |
| now_ns | output | 38 | Current nanoseconds: 37:8 whole ns, 7:0 fraction |

## Verification
The hardest case to reach is an adjustment that is cut short or restarted at a nanosecond rollover. A fresh adjustment load, a period load and a time load must meet within a few edges of each other, so that the step selection, the carry into seconds and the done pulse all interact. Directed sequences drive each collision on purpose. Time loads land a few steps below one billion nanoseconds and near the top of the seconds range. The random phase keeps adjustment counts small and places time loads near the wrap point, so the collisions come up often. Every edge is compared against a bench model of the requirements.

// File: rtl/ptp_rtc_pkg.sv
package ptp_rtc_pkg;
  localparam int unsigned DEF_SEC_W      = 48;
  localparam int unsigned DEF_NS_W       = 30;
  localparam int unsigned DEF_FRAC_W     = 32;
  localparam int unsigned DEF_OUT_FRAC_W = 8;
  localparam int unsigned DEF_PER_INT_W  = 8;
  localparam int unsigned DEF_CNT_W      = 32;
  localparam longint unsigned DEF_NS_MOD = 64'd1000000000;

  // which period feeds the accumulator this cycle
  typedef enum logic {
    STEP_NOMINAL = 1'b0,
    STEP_ADJUST  = 1'b1
  } step_src_e;
endpackage

// File: rtl/ptp_rtc_rst_sync.sv
module ptp_rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptp_rtc_adjust.sv
module ptp_rtc_adjust
  import ptp_rtc_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int PER_W = DEF_PER_INT_W + DEF_FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adj_load,
  input  logic [CNT_W-1:0] adj_cycles,
  input  logic [PER_W-1:0] adj_period,
  output step_src_e        step_src,
  output logic [PER_W-1:0] alt_period,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PER_W-1:0] alt_q;
  logic             cnt_en, busy, last, done_n;

  // next state
  always_comb begin
    busy   = (cnt_q != '0);
    last   = (cnt_q == CNT_W'(1));
    cnt_en = adj_load | busy;
    cnt_n  = adj_load ? adj_cycles : (cnt_q - CNT_W'(1));
    done_n = last & ~adj_load;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alt_q <= '0;
      done  <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q <= cnt_n;
      if (adj_load) alt_q <= adj_period;
      done <= done_n;
    end
  end

  assign step_src   = busy ? STEP_ADJUST : STEP_NOMINAL;
  assign alt_period = alt_q;
endmodule

// File: rtl/ptp_rtc_rate.sv
module ptp_rtc_rate
  import ptp_rtc_pkg::*;
#(
  parameter int PER_W = DEF_PER_INT_W + DEF_FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_load,
  input  logic [PER_W-1:0] period_in,
  input  step_src_e        step_src,
  input  logic [PER_W-1:0] alt_period,
  output logic [PER_W-1:0] step_inc
);
  logic [PER_W-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           per_q <= '0;
    else if (period_load) per_q <= period_in;
  end

  always_comb begin
    step_inc = (step_src == STEP_ADJUST) ? alt_period : per_q;
  end
endmodule

// File: rtl/ptp_rtc_accum.sv
module ptp_rtc_accum
  import ptp_rtc_pkg::*;
#(
  parameter int              SEC_W      = DEF_SEC_W,
  parameter int              NS_W       = DEF_NS_W,
  parameter int              FRAC_W     = DEF_FRAC_W,
  parameter int              OUT_FRAC_W = DEF_OUT_FRAC_W,
  parameter int              PER_W      = DEF_PER_INT_W + DEF_FRAC_W,
  parameter longint unsigned NS_MOD     = DEF_NS_MOD
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       time_load,
  input  logic [NS_W+OUT_FRAC_W-1:0] load_ns,
  input  logic [SEC_W-1:0]           load_sec,
  input  logic [PER_W-1:0]           step_inc,
  output logic [SEC_W-1:0]           time_sec,
  output logic [NS_W+OUT_FRAC_W-1:0] time_ns
);
  localparam int ACC_W = NS_W + FRAC_W + 1;
  localparam int PAD   = FRAC_W - OUT_FRAC_W;
  localparam logic [NS_W:0] WRAP_AT = (NS_W+1)'(NS_MOD);

  logic [SEC_W-1:0]  sec_q, sec_n;
  logic [NS_W-1:0]   ns_q, ns_n;
  logic [FRAC_W-1:0] frac_q, frac_n;
  logic [ACC_W-1:0]  sum;
  logic [NS_W:0]     sum_ns;
  logic              wrap;

  // next state: load has priority over the accumulate step
  always_comb begin
    sum    = {1'b0, ns_q, frac_q} + ACC_W'(step_inc);
    sum_ns = sum[ACC_W-1:FRAC_W];
    wrap   = (sum_ns >= WRAP_AT);
    if (time_load) begin
      sec_n  = load_sec;
      ns_n   = load_ns[NS_W+OUT_FRAC_W-1:OUT_FRAC_W];
      frac_n = FRAC_W'(load_ns[OUT_FRAC_W-1:0]) << PAD;
    end else begin
      sec_n  = sec_q + SEC_W'(wrap);
      ns_n   = wrap ? NS_W'(sum_ns - WRAP_AT) : sum_ns[NS_W-1:0];
      frac_n = sum[FRAC_W-1:0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else begin
      sec_q  <= sec_n;
      ns_q   <= ns_n;
      frac_q <= frac_n;
    end
  end

  assign time_sec = sec_q;
  assign time_ns  = {ns_q, frac_q[FRAC_W-1 -: OUT_FRAC_W]};
endmodule

// File: rtl/ptp_rtc.sv
module ptp_rtc
  import ptp_rtc_pkg::*;
#(
  parameter int              SEC_W      = DEF_SEC_W,
  parameter int              NS_W       = DEF_NS_W,
  parameter int              FRAC_W     = DEF_FRAC_W,
  parameter int              OUT_FRAC_W = DEF_OUT_FRAC_W,
  parameter int              PER_INT_W  = DEF_PER_INT_W,
  parameter int              CNT_W      = DEF_CNT_W,
  parameter longint unsigned NS_MOD     = DEF_NS_MOD,
  localparam int             PER_W      = PER_INT_W + FRAC_W,
  localparam int             TNS_W      = NS_W + OUT_FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             time_load,
  input  logic [TNS_W-1:0] time_ns_in,
  input  logic [SEC_W-1:0] time_sec_in,
  input  logic             period_load,
  input  logic [PER_W-1:0] period_in,
  input  logic             adj_load,
  input  logic [CNT_W-1:0] adj_cycles_in,
  input  logic [PER_W-1:0] adj_period_in,
  output logic             adj_done,
  output logic [SEC_W-1:0] now_sec,
  output logic [TNS_W-1:0] now_ns
);
  logic             rst_core_n;
  step_src_e        step_src;
  logic [PER_W-1:0] alt_period;
  logic [PER_W-1:0] step_inc;

  ptp_rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  ptp_rtc_adjust #(.CNT_W(CNT_W), .PER_W(PER_W)) u_adj (
    .clk(clk), .rst_n(rst_core_n), .adj_load(adj_load),
    .adj_cycles(adj_cycles_in), .adj_period(adj_period_in),
    .step_src(step_src), .alt_period(alt_period), .done(adj_done)
  );

  ptp_rtc_rate #(.PER_W(PER_W)) u_rate (
    .clk(clk), .rst_n(rst_core_n), .period_load(period_load),
    .period_in(period_in), .step_src(step_src),
    .alt_period(alt_period), .step_inc(step_inc)
  );

  ptp_rtc_accum #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
    .OUT_FRAC_W(OUT_FRAC_W), .PER_W(PER_W), .NS_MOD(NS_MOD)
  ) u_acc (
    .clk(clk), .rst_n(rst_core_n), .time_load(time_load),
    .load_ns(time_ns_in), .load_sec(time_sec_in), .step_inc(step_inc),
    .time_sec(now_sec), .time_ns(now_ns)
  );
endmodule

// File: rtl/ptp_rtc_chk.sv
module ptp_rtc_chk #(
  parameter int              SEC_W  = 48,
  parameter int              TNS_W  = 38,
  parameter int              NS_LSB = 8,
  parameter int              CNT_W  = 32,
  parameter longint unsigned NS_MOD = 64'd1000000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             time_load,
  input logic [TNS_W-1:0] time_ns_in,
  input logic [SEC_W-1:0] time_sec_in,
  input logic             adj_load,
  input logic [CNT_W-1:0] adj_cycles_in,
  input logic             adj_done,
  input logic [SEC_W-1:0] now_sec,
  input logic [TNS_W-1:0] now_ns
);
  localparam logic [TNS_W-NS_LSB-1:0] LIMIT = (TNS_W-NS_LSB)'(NS_MOD);

  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> (now_sec == $past(time_sec_in)) && (now_ns == $past(time_ns_in))); // R2

  AST_NS_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !time_load |=> (now_ns[TNS_W-1:NS_LSB] < LIMIT)); // R4

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !time_load |=> (now_sec == $past(now_sec)) || (now_sec == $past(now_sec) + SEC_W'(1))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adj_done |=> !adj_done); // R8

  AST_ZERO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_load && adj_cycles_in == '0) |=> !adj_done); // R9

  AST_RELOAD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    adj_load |=> !adj_done); // R10
endmodule

bind ptp_rtc ptp_rtc_chk #(
  .SEC_W(SEC_W), .TNS_W(TNS_W), .NS_LSB(OUT_FRAC_W),
  .CNT_W(CNT_W), .NS_MOD(NS_MOD)
) u_chk (
  .clk(clk), .rst_n(rst_core_n), .time_load(time_load),
  .time_ns_in(time_ns_in), .time_sec_in(time_sec_in),
  .adj_load(adj_load), .adj_cycles_in(adj_cycles_in),
  .adj_done(adj_done), .now_sec(now_sec), .now_ns(now_ns)
);

// File: tb/tb_ptp_rtc.sv
`timescale 1ns/1ps
module tb_ptp_rtc;
  localparam logic [29:0] WRAP = 30'd1000000000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        time_load, period_load, adj_load;
  logic [37:0] time_ns_in;
  logic [47:0] time_sec_in;
  logic [39:0] period_in, adj_period_in;
  logic [31:0] adj_cycles_in;
  logic        adj_done;
  logic [47:0] now_sec;
  logic [37:0] now_ns;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ptp_rtc dut (
    .clk(clk), .rst_n(rst_n), .time_load(time_load), .time_ns_in(time_ns_in),
    .time_sec_in(time_sec_in), .period_load(period_load), .period_in(period_in),
    .adj_load(adj_load), .adj_cycles_in(adj_cycles_in), .adj_period_in(adj_period_in),
    .adj_done(adj_done), .now_sec(now_sec), .now_ns(now_ns)
  );

  // reference model state
  logic [47:0] m_sec;
  logic [29:0] m_ns;
  logic [31:0] m_frac;
  logic [39:0] m_per, m_adjp;
  logic [31:0] m_cnt;
  logic        m_done;

  // one accumulate step: returns {carry, ns, frac}
  function automatic logic [62:0] acc_step(logic [29:0] ns, logic [31:0] fr, logic [39:0] inc);
    logic [63:0] s;
    logic [30:0] whole;
    s = {2'b00, ns, fr} + {24'd0, inc};
    whole = s[62:32];
    if (whole >= {1'b0, WRAP}) return {1'b1, 30'(whole - {1'b0, WRAP}), s[31:0]};
    return {1'b0, whole[29:0], s[31:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [39:0] inc;
    logic [62:0] r;
    if (!rst_n) begin
      m_sec = '0; m_ns = '0; m_frac = '0; m_per = '0; m_adjp = '0; m_cnt = '0; m_done = 1'b0;
    end else begin
      inc = (m_cnt != 0) ? m_adjp : m_per;
      r = acc_step(m_ns, m_frac, inc);
      m_done = (m_cnt == 32'd1) && !adj_load;
      if (adj_load) begin m_cnt = adj_cycles_in; m_adjp = adj_period_in; end
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      if (period_load) m_per = period_in;
      if (time_load) begin
        m_sec = time_sec_in; m_ns = time_ns_in[37:8]; m_frac = {time_ns_in[7:0], 24'd0};
      end else begin
        m_sec = m_sec + {47'd0, r[62]}; m_ns = r[61:32]; m_frac = r[31:0];
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    time_load = 0; period_load = 0; adj_load = 0;
  endtask

  // advance one edge, release strobes, compare against the model
  task automatic tick(string tag);
    @(posedge clk); #1;
    clear_in();
    chk(tag, "now_sec", 64'(now_sec), 64'(m_sec));
    chk(tag, "now_ns", 64'(now_ns), 64'({m_ns, m_frac[31:24]}));
    chk(tag, "adj_done", 64'(adj_done), 64'(m_done));
  endtask

  task automatic load_time(logic [47:0] s, logic [29:0] ns, logic [7:0] f);
    time_load = 1; time_sec_in = s; time_ns_in = {ns, f};
  endtask

  task automatic load_adj(logic [31:0] n, logic [39:0] p);
    adj_load = 1; adj_cycles_in = n; adj_period_in = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_in();
    time_ns_in = '0; time_sec_in = '0; period_in = '0; adj_period_in = '0; adj_cycles_in = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "now_sec in reset", 64'(now_sec), 64'd0);
    chk("R1", "now_ns in reset", 64'(now_ns), 64'd0);
    chk("R1", "adj_done in reset", 64'(adj_done), 64'd0);
    rst_n = 1;
    // zero period after reset: time holds still
    repeat (4) tick("R1");
    chk("R1", "time held at zero", 64'({now_sec, 16'd0} | 64'(now_ns)), 64'd0);

    // R2: load time and period together, time a few steps below wrap
    load_time(48'd5, 30'd999999990, 8'h80);
    period_in = 40'h08_0000_0000; period_load = 1;
    tick("R2");
    chk("R2", "loaded ns", 64'(now_ns), 64'({30'd999999990, 8'h80}));
    chk("R2", "loaded sec", 64'(now_sec), 64'd5);
    // R4: two steps of 8 ns cross one billion
    tick("R4");
    tick("R4");
    chk("R4", "wrapped ns", 64'(now_ns), 64'({30'd6, 8'h80}));
    chk("R4", "carried sec", 64'(now_sec), 64'd6);

    // R2: load during running accumulate wins
    load_time(48'd100, 30'd1000, 8'h00);
    tick("R2");
    chk("R2", "load priority ns", 64'(now_ns), 64'({30'd1000, 8'h00}));

    // R6: new period applies from the following edge
    period_in = 40'h03_8000_0000; period_load = 1;
    tick("R6");
    chk("R6", "old period on load edge", 64'(now_ns), 64'({30'd1008, 8'h00}));
    tick("R6");
    chk("R6", "new period next edge", 64'(now_ns), 64'({30'd1011, 8'h80}));

    // R3: fraction below the output resolution accumulates
    period_in = 40'h07_FFFF_FFFF; period_load = 1;
    repeat (20) tick("R3");

    // R5: seconds roll over from all ones
    load_time(48'hFFFF_FFFF_FFFF, 30'd999999999, 8'hF0);
    tick("R2");
    tick("R5");
    chk("R5", "seconds wrapped", 64'(now_sec), 64'd0);

    // R7/R8: three adjusted steps of 16 ns then done
    period_in = 40'h08_0000_0000; period_load = 1;
    tick("R7");
    load_time(48'd10, 30'd0, 8'h00);
    load_adj(32'd3, 40'h10_0000_0000);
    tick("R7");
    tick("R7"); tick("R7"); tick("R7");
    chk("R7", "after 3 adjusted steps", 64'(now_ns), 64'({30'd48, 8'h00}));
    chk("R8", "done after last step", 64'(adj_done), 64'd1);
    tick("R8");
    chk("R8", "done drops", 64'(adj_done), 64'd0);
    chk("R7", "nominal again", 64'(now_ns), 64'({30'd56, 8'h00}));

    // R8: single-cycle adjustment
    load_adj(32'd1, 40'h00_8000_0000);
    repeat (4) tick("R8");

    // R9: cancel with zero count
    load_adj(32'd6, 40'h20_0000_0000);
    tick("R9"); tick("R9");
    load_adj(32'd0, 40'h00_0000_0000);
    repeat (8) begin
      tick("R9");
      chk("R9", "no done after cancel", 64'(adj_done), 64'd0);
    end

    // R10: restart during a running adjustment
    load_adj(32'd4, 40'h0C_0000_0000);
    tick("R10"); tick("R10");
    load_adj(32'd2, 40'h01_4000_0000);
    repeat (6) tick("R10");

    // random mix with time loads near the wrap point
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0)
        load_time(48'($urandom) | ({16'($urandom), 32'd0} & 48'hFFFF_0000_0000),
                  30'd999999000 + 30'($urandom_range(0, 1000)), 8'($urandom));
      if ($urandom_range(0, 29) == 0) begin
        period_load = 1; period_in = {8'($urandom_range(1, 255)), 32'($urandom)};
      end
      if ($urandom_range(0, 29) == 0)
        load_adj(32'($urandom_range(0, 6)), {8'($urandom), 32'($urandom)});
      tick("R3");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule